// File: doc/BRIEF.md
# DC-Blocking High-Pass Filter

This block removes a constant offset from a stream of decimated audio samples before they are stored. It is a first-order IIR high-pass stage with one pole and one zero. It runs once per accepted sample, so it works at the output sample rate. The pole sits at a = 1 - 2^-11 (about 0.99951). At a 44.1 kHz rate this puts the -3 dB corner near 3.4 Hz, and the corner moves in proportion to the sample rate. The response falls monotonically toward DC and has no ripple in the passband. At 20 Hz it loses roughly a tenth of a dB.

Each sample arrives with a one-cycle strobe and a channel tag. Every channel has its own previous-input and feedback state. The filtered sample leaves one clock later with the same tag.

The feedback state carries FRAC_W fractional bits below the sample LSB. The leak term y/2^11 is rounded away from zero, so the magnitude of the state always shrinks when there is no new input difference. A constant input therefore decays to an output of exactly zero. It does not stall in a small limit cycle. The output is rounded half-up to the sample width and clamped at the two's-complement limits.

Top module: `dc_block_hpf`

## Requirements
- R1: While rst_n is low and on the first cycle after it, out_valid is 0 and out_data is 0. Reset clears every channel's previous input and feedback state to zero.
- R2: out_valid is 1 in exactly the cycle after a cycle with in_valid = 1, and 0 otherwise.
- R3: out_ch equals the in_ch of the sample that produced the current output.
- R4: out_data and out_ch keep their values in every cycle after a cycle with in_valid = 0.
- R5: Each channel follows y[n] = x[n] - x[n-1] + y[n-1] - leak. The leak is y[n-1]/2^11 rounded away from zero, and the state holds FRAC_W = 10 extra fractional bits. Each output stays within 2 LSB of the ideal real filter with a = 1 - 2^-11, clamped to the sample range.
- R6: The first sample on a channel after reset comes out unchanged (out_data = in_data).
- R7: The output is limited to the range -32768 to 32767 (16-bit two's complement). Results outside that range give the nearer limit.
- R8: Once a constant input has been applied for long enough (25000 samples from a 1000-LSB step), the output is exactly 0.
- R9: A sample on one channel does not change the state of any other channel.
- R10: in_data and in_ch are ignored while in_valid is 0, and the next valid sample's result is unaffected by them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: in_data/in_ch hold a sample this cycle |
| in_ch | input | CH_W (1) | Channel tag of the incoming sample |
| in_data | input | DATA_W (16) | Signed incoming sample |
| out_valid | output | 1 | Strobe: out_data holds a filtered sample |
| out_ch | output | CH_W (1) | Channel tag of the filtered sample |
| out_data | output | DATA_W (16) | Signed filtered sample, rounded and clamped |

## Verification
The checker watches the strobe and tag timing on every cycle. It checks the one-cycle latency, the tag following its sample, and the output holding between strobes. The numeric behaviour can only be shown by the bench's scenarios, because it depends on sample history. That covers agreement with a real-valued model of the recurrence, exact pass-through of a first sample, clamping at both limits, independence of the two channels, and decay of a constant input to exactly zero.

// File: rtl/dcb_hpf_pkg.sv
package dcb_hpf_pkg;

    localparam int DEF_DATA_W     = 16;
    localparam int DEF_FRAC_W     = 10;
    localparam int DEF_POLE_SHIFT = 11;
    localparam int DEF_NUM_CH     = 2;

    // Tag width; at least one bit so the port never collapses.
    function automatic int tag_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dcb_hpf_core.sv
// One recurrence step: next feedback state from sample, previous sample and state.
module dcb_hpf_core #(
    parameter int DATA_W     = 16,
    parameter int FRAC_W     = 10,
    parameter int POLE_SHIFT = 11,
    parameter int STATE_W    = DATA_W + FRAC_W + 3
) (
    input  logic signed [DATA_W-1:0]  x_cur,
    input  logic signed [DATA_W-1:0]  x_last,
    input  logic signed [STATE_W-1:0] y_last,
    output logic signed [STATE_W-1:0] y_next
);
    localparam int SUM_W = STATE_W + 1;

    logic signed [DATA_W:0]    diff;
    logic signed [SUM_W-1:0]   diff_ext;
    logic signed [SUM_W-1:0]   diff_scaled;
    logic signed [SUM_W-1:0]   y_ext;
    logic signed [SUM_W-1:0]   leak_bias;
    logic signed [SUM_W-1:0]   leak;
    logic signed [SUM_W-1:0]   sum_full;
    logic                      y_is_pos;

    always_comb begin
        diff        = {x_cur[DATA_W-1], x_cur} - {x_last[DATA_W-1], x_last};
        diff_ext    = {{(SUM_W-DATA_W-1){diff[DATA_W]}}, diff};
        diff_scaled = diff_ext <<< FRAC_W;
        y_ext       = {y_last[STATE_W-1], y_last};
        // Leak rounded away from zero: a positive state gets a ceiling,
        // a negative one keeps the floor of the arithmetic shift.
        y_is_pos    = !y_last[STATE_W-1] && (y_last != '0);
        leak_bias   = y_is_pos ? {{(SUM_W-POLE_SHIFT){1'b0}}, {POLE_SHIFT{1'b1}}}
                               : '0;
        leak        = (y_ext + leak_bias) >>> POLE_SHIFT;
        sum_full    = y_ext + diff_scaled - leak;
        y_next      = sum_full[STATE_W-1:0];
    end
endmodule

// File: rtl/dcb_hpf_quant.sv
// Round half-up from the extended state to sample width, then clamp.
module dcb_hpf_quant #(
    parameter int DATA_W  = 16,
    parameter int FRAC_W  = 10,
    parameter int STATE_W = DATA_W + FRAC_W + 3
) (
    input  logic signed [STATE_W-1:0] y_state,
    output logic signed [DATA_W-1:0]  y_out
);
    localparam int SUM_W = STATE_W + 1;

    localparam logic signed [SUM_W-1:0] HALF_LSB =
        {{(SUM_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] POS_LIM =
        {{(SUM_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] NEG_LIM =
        {{(SUM_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [SUM_W-1:0] biased;
    logic signed [SUM_W-1:0] whole;

    always_comb begin
        biased = {y_state[STATE_W-1], y_state} + HALF_LSB;
        whole  = biased >>> FRAC_W;
        if (whole > POS_LIM) begin
            y_out = POS_LIM[DATA_W-1:0];
        end else if (whole < NEG_LIM) begin
            y_out = NEG_LIM[DATA_W-1:0];
        end else begin
            y_out = whole[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/dc_block_hpf.sv
module dc_block_hpf
    import dcb_hpf_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int FRAC_W     = DEF_FRAC_W,
    parameter int POLE_SHIFT = DEF_POLE_SHIFT,
    parameter int NUM_CH     = DEF_NUM_CH,
    parameter int CH_W       = tag_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_ch,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_ch,
    output logic [DATA_W-1:0] out_data
);
    localparam int STATE_W = DATA_W + FRAC_W + 3;

    typedef struct packed {
        logic                             vld;
        logic [CH_W-1:0]                  ch;
        logic [DATA_W-1:0]                dat;
        logic [NUM_CH-1:0][DATA_W-1:0]    x_prev;
        logic [NUM_CH-1:0][STATE_W-1:0]   y_fb;
    } hpf_regs_t;

    hpf_regs_t regs_d, regs_q;

    logic signed [DATA_W-1:0]  sel_x_prev;
    logic signed [STATE_W-1:0] sel_y_fb;
    logic signed [STATE_W-1:0] step_y;
    logic signed [DATA_W-1:0]  step_out;

    always_comb begin
        sel_x_prev = $signed(regs_q.x_prev[in_ch]);
        sel_y_fb   = $signed(regs_q.y_fb[in_ch]);
    end

    dcb_hpf_core #(
        .DATA_W    (DATA_W),
        .FRAC_W    (FRAC_W),
        .POLE_SHIFT(POLE_SHIFT),
        .STATE_W   (STATE_W)
    ) core_i (
        .x_cur ($signed(in_data)),
        .x_last(sel_x_prev),
        .y_last(sel_y_fb),
        .y_next(step_y)
    );

    dcb_hpf_quant #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .STATE_W(STATE_W)
    ) quant_i (
        .y_state(step_y),
        .y_out  (step_out)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.vld = in_valid;
        if (in_valid) begin
            regs_d.ch            = in_ch;
            regs_d.dat           = step_out;
            regs_d.x_prev[in_ch] = in_data;
            regs_d.y_fb[in_ch]   = step_y;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign out_valid = regs_q.vld;
    assign out_ch    = regs_q.ch;
    assign out_data  = regs_q.dat;

endmodule

// File: rtl/dcb_hpf_chk.sv
module dcb_hpf_chk #(
    parameter int DATA_W = 16,
    parameter int CH_W   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [CH_W-1:0]   in_ch,
    input logic              out_valid,
    input logic [CH_W-1:0]   out_ch,
    input logic [DATA_W-1:0] out_data
);
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                   // R2
    AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                 // R2
    AST_TAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_ch == $past(in_ch)));                    // R3
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));                          // R4
    AST_HOLD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_ch));                            // R4
endmodule

bind dc_block_hpf dcb_hpf_chk #(
    .DATA_W(DATA_W),
    .CH_W  (CH_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ch    (in_ch),
    .out_valid(out_valid),
    .out_ch   (out_ch),
    .out_data (out_data)
);

// File: tb/dc_block_hpf_tb_top.sv
module dc_block_hpf_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [0:0]  in_ch = '0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [0:0]  out_ch;
    logic [15:0] out_data;

    int n_checks = 0;
    int n_bad    = 0;
    int cycles   = 0;

    real mdl_y [2];
    int  mdl_xp[2];
    localparam real POLE = 1.0 - 1.0 / 2048.0;

    always #4 clk = ~clk;

    dc_block_hpf dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
        .in_data(in_data), .out_valid(out_valid), .out_ch(out_ch),
        .out_data(out_data)
    );

    // Stimulus/expected table: channel, sample, expected, exact flag
    localparam int TV_N = 8;
    localparam int TV_CH [TV_N] = '{0, 1, 0, 1, 0, 1, 0, 1};
    localparam int TV_X  [TV_N] = '{100, -200, 100, 300, 400, 300, 0, 0};
    localparam int TV_EXP[TV_N] = '{100, -200, 100, 300, 400, 300, 0, 0};
    localparam int TV_EX [TV_N] = '{1, 1, 0, 0, 0, 0, 0, 0};

    task automatic check(input string req, input int got, input int exp, input int tol);
        int d;
        n_checks++;
        d = got - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (tol %0d)", req, got, exp, tol);
        end
    endtask

    function automatic int clamp_round(input real v);
        int r;
        r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic int mdl_step(input int ch, input int x);
        mdl_y[ch]  = real'(x - mdl_xp[ch]) + POLE * mdl_y[ch];
        mdl_xp[ch] = x;
        return clamp_round(mdl_y[ch]);
    endfunction

    task automatic mdl_clear();
        for (int c = 0; c < 2; c++) begin
            mdl_y[c]  = 0.0;
            mdl_xp[c] = 0;
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with the result.
    task automatic send(input int ch, input int x, output int y, output int v, output int t);
        in_valid = 1'b1;
        in_ch    = ch[0:0];
        in_data  = x[15:0];
        @(negedge clk);
        y = int'($signed(out_data));
        v = int'(out_valid);
        t = int'(out_ch);
        in_valid = 1'b0;
        in_data  = 16'h5A5A;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0, 0);
        check("R1 data in reset", int'($signed(out_data)), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0, 0);
        check("R1 data after reset", int'($signed(out_data)), 0, 0);
        mdl_clear();
    endtask

    initial begin : watchdog
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("%0d/%0d checks passed", n_checks - n_bad, n_checks);
        $finish;
    end

    initial begin : main
        int y, v, t, e, held;
        @(negedge clk);
        do_reset();

        // Table walk: R2, R3, R5, R6
        for (int i = 0; i < TV_N; i++) begin
            e = mdl_step(TV_CH[i], TV_X[i]);
            send(TV_CH[i], TV_X[i], y, v, t);
            check("R2 strobe", v, 1, 0);
            check("R3 tag", t, TV_CH[i], 0);
            if (TV_EX[i] != 0) check("R6 first sample", y, TV_EXP[i], 0);
            else               check("R5 table", y, TV_EXP[i], 2);
            check("R5 model", y, e, 2);
        end

        // R4/R10: idle cycles with garbage on the inputs
        held = y;
        for (int k = 0; k < 4; k++) begin
            in_ch   = k[0:0];
            in_data = 16'(k * 7919 - 12000);
            @(negedge clk);
            check("R4 hold data", int'($signed(out_data)), held, 0);
            check("R4 hold tag", int'(out_ch), 1, 0);
            check("R2 no strobe", int'(out_valid), 0, 0);
        end
        e = mdl_step(0, 250);
        send(0, 250, y, v, t);
        check("R10 ignored idle input", y, e, 2);

        // R8 constant input settles to zero on channel 0; R9 channel 1 untouched
        for (int k = 0; k < 25000; k++) begin
            e = mdl_step(0, 1000);
            send(0, 1000, y, v, t);
            if (k == 0) check("R5 step", y, e, 2);
        end
        check("R8 settled to zero", y, 0, 0);
        e = mdl_step(1, 700);
        send(1, 700, y, v, t);
        check("R9 other channel unchanged", y, e, 2);

        // Mid-run reset, then pass-through and saturation
        do_reset();
        e = mdl_step(0, -5000);
        send(0, -5000, y, v, t);
        check("R6 after reset", y, -5000, 0);
        e = mdl_step(1, 32767);
        send(1, 32767, y, v, t);
        check("R6 full scale", y, 32767, 0);
        e = mdl_step(1, -32768);
        send(1, -32768, y, v, t);
        check("R7 negative clamp", y, -32768, 0);
        e = mdl_step(1, 32767);
        send(1, 32767, y, v, t);
        check("R7 positive swing", y, e, 2);
        e = mdl_step(0, 32767);
        send(0, 32767, y, v, t);
        check("R7 positive clamp", y, 32767, 0);
        check("R3 tag after clamp", t, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_bad, n_checks);
        $finish;
    end

endmodule